// File: doc/BRIEF.md
# Sticky Error Status Aggregator

This block gathers short error pulses from a bank of FIFO monitors and from a set of state-machine and counter integrity checkers, and folds them into one 32-bit status word that software can only read. Each source owns one bit that is set by its first pulse and then stays set until the block is reset. FIFO faults are also classified by cause in three shared type bits: overflow (a write into a full FIFO), underflow (a read from an empty FIFO) and an inconsistent state (full and empty reported together).

A test port lets software name a bit index. If register writes are unlocked, the block produces a one-clock internal error pulse on that bit, so the route from a source bit to the interrupt and the alert can be tested without a real fault. The block drives a fatal-error interrupt request, held high while any status bit is set. It also drives a fatal alert, held high while any checker bit is set.

Top module: `err_sticky_agg`

## Requirements
- R1: After reset the status word, the interrupt request and the fatal alert are all zero.
- R2: A pulse on FIFO error input i (i from 0 to 15) sets status bit i at the next rising clock edge.
- R3: A FIFO error pulse that arrives while that FIFO's write qualifier and full flag are both high also sets status bit 28 (overflow type) at the same edge.
- R4: A FIFO error pulse that arrives while that FIFO's read qualifier and empty flag are both high also sets status bit 29 (underflow type) at the same edge.
- R5: A FIFO error pulse that arrives while that FIFO's full and empty flags are both high also sets status bit 30 (state type) at the same edge.
- R6: A FIFO error pulse that matches none of the three causes sets only its own source bit and no type bit.
- R7: A pulse on checker input j sets status bit 20+j at the next edge. The checker order is: 0 command stage, 1 main control, 2 generate, 3 update block-encrypt, 4 update output-block, 5 cipher fatal fault, 6 redundant counter mismatch.
- R8: A status bit that has been set stays set until reset, whatever happens on the other inputs, the test port included.
- R9: When the test strobe is high while the write enable is high, the indexed status bit becomes set two rising edges after the strobe (one edge to form a one-clock internal pulse, one to capture it). No other bit changes.
- R10: When the write enable is low, a test strobe has no effect on the status word.
- R11: Bits 16 to 19, bit 27 and bit 31 always read as zero, even when the test port targets them.
- R12: The interrupt request is high exactly while the status word is non-zero.
- R13: The fatal alert is high exactly while any of status bits 20 to 26 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_err_i | input | 16 | Per-FIFO error pulse |
| fifo_full_i | input | 16 | Per-FIFO full flag |
| fifo_empty_i | input | 16 | Per-FIFO empty flag |
| fifo_wr_i | input | 16 | Per-FIFO write qualifier |
| fifo_rd_i | input | 16 | Per-FIFO read qualifier |
| chk_err_i | input | 7 | Per-checker illegal-state or mismatch pulse |
| cfg_wen_i | input | 1 | Register write enable; low locks the test port |
| test_wr_i | input | 1 | Test-register write strobe |
| test_idx_i | input | 5 | Bit index to force |
| err_status_o | output | 32 | Sticky status word |
| fatal_irq_o | output | 1 | Fatal-error interrupt request, level |
| fatal_alert_o | output | 1 | Fatal alert, level |

## Verification
The bench builds the block with its default sizes: sixteen FIFO sources and seven checkers. With these sizes the full status layout is reachable: the reserved gaps at 16 to 19 and at 27 sit between real fields, and every one of the 32 test indices lands on a source bit, a type bit or a reserved hole. Random qualifier patterns reach all combinations of full, empty, read and write, so the three type bits are set alone and together. Repeated resets between trials show that bits stay set and come back cleared.

// File: rtl/errsum_pkg.sv
package errsum_pkg;

  parameter int unsigned WORD_W   = 32;
  parameter int unsigned IDX_W    = 5;
  parameter int unsigned FIFO_LSB = 0;
  parameter int unsigned CHK_LSB  = 20;
  parameter int unsigned TYPE_WR  = 28;
  parameter int unsigned TYPE_RD  = 29;
  parameter int unsigned TYPE_ST  = 30;

  typedef struct packed {
    logic st;
    logic rd;
    logic wr;
  } fifo_cause_t;

  // Cause of one FIFO error pulse.
  function automatic fifo_cause_t classify(input logic pulse, input logic full,
                                           input logic empty, input logic wr,
                                           input logic rd);
    fifo_cause_t c;
    c.wr = pulse & wr & full;
    c.rd = pulse & rd & empty;
    c.st = pulse & full & empty;
    return c;
  endfunction

  // Bits that can ever hold a one.
  function automatic logic [WORD_W-1:0] live_mask(input int unsigned nfifo,
                                                  input int unsigned nchk);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(nfifo); i++) m[FIFO_LSB + i] = 1'b1;
    for (int j = 0; j < int'(nchk); j++)  m[CHK_LSB + j]  = 1'b1;
    m[TYPE_WR] = 1'b1;
    m[TYPE_RD] = 1'b1;
    m[TYPE_ST] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] index_to_bit(input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/err_force_gen.sv
module err_force_gen
  import errsum_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] force_o
);
  logic [WORD_W-1:0] force_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            force_q <= '0;
    else if (wr_i && wen_i) force_q <= index_to_bit(idx_i);
    else                    force_q <= '0;
  end

  assign force_o = force_q;
endmodule

// File: rtl/fifo_err_classify.sv
module fifo_err_classify
  import errsum_pkg::*;
#(
  parameter int unsigned NUM_FIFO = 16
) (
  input  logic [NUM_FIFO-1:0] err_i,
  input  logic [NUM_FIFO-1:0] full_i,
  input  logic [NUM_FIFO-1:0] empty_i,
  input  logic [NUM_FIFO-1:0] wr_i,
  input  logic [NUM_FIFO-1:0] rd_i,
  output fifo_cause_t         cause_o
);
  logic [NUM_FIFO-1:0] wr_hit, rd_hit, st_hit;

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
    fifo_cause_t c;
    assign c         = classify(err_i[g], full_i[g], empty_i[g], wr_i[g], rd_i[g]);
    assign wr_hit[g] = c.wr;
    assign rd_hit[g] = c.rd;
    assign st_hit[g] = c.st;
  end

  assign cause_o.wr = |wr_hit;
  assign cause_o.rd = |rd_hit;
  assign cause_o.st = |st_hit;
endmodule

// File: rtl/err_sticky_word.sv
module err_sticky_word
  import errsum_pkg::*;
#(
  parameter logic [WORD_W-1:0] KEEP = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] set_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= (word_q | set_i) & KEEP;
  end

  assign word_o = word_q;
endmodule

// File: rtl/err_sticky_agg.sv
module err_sticky_agg
  import errsum_pkg::*;
#(
  parameter int unsigned NUM_FIFO = 16,
  parameter int unsigned NUM_CHK  = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_FIFO-1:0] fifo_err_i,
  input  logic [NUM_FIFO-1:0] fifo_full_i,
  input  logic [NUM_FIFO-1:0] fifo_empty_i,
  input  logic [NUM_FIFO-1:0] fifo_wr_i,
  input  logic [NUM_FIFO-1:0] fifo_rd_i,
  input  logic [NUM_CHK-1:0]  chk_err_i,
  input  logic                cfg_wen_i,
  input  logic                test_wr_i,
  input  logic [IDX_W-1:0]    test_idx_i,
  output logic [WORD_W-1:0]   err_status_o,
  output logic                fatal_irq_o,
  output logic                fatal_alert_o
);
  localparam logic [WORD_W-1:0] KEEP_MASK = live_mask(NUM_FIFO, NUM_CHK);

  // Named internal events, visible to the checker.
  logic [WORD_W-1:0] force_vec;
  fifo_cause_t       fifo_cause;
  logic [WORD_W-1:0] set_vec;

  err_force_gen u_force (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wen_i  (cfg_wen_i),
    .wr_i   (test_wr_i),
    .idx_i  (test_idx_i),
    .force_o(force_vec)
  );

  fifo_err_classify #(.NUM_FIFO(NUM_FIFO)) u_class (
    .err_i  (fifo_err_i),
    .full_i (fifo_full_i),
    .empty_i(fifo_empty_i),
    .wr_i   (fifo_wr_i),
    .rd_i   (fifo_rd_i),
    .cause_o(fifo_cause)
  );

  always_comb begin
    set_vec = force_vec;
    for (int i = 0; i < int'(NUM_FIFO); i++)
      set_vec[FIFO_LSB + i] = set_vec[FIFO_LSB + i] | fifo_err_i[i];
    for (int j = 0; j < int'(NUM_CHK); j++)
      set_vec[CHK_LSB + j] = set_vec[CHK_LSB + j] | chk_err_i[j];
    set_vec[TYPE_WR] = set_vec[TYPE_WR] | fifo_cause.wr;
    set_vec[TYPE_RD] = set_vec[TYPE_RD] | fifo_cause.rd;
    set_vec[TYPE_ST] = set_vec[TYPE_ST] | fifo_cause.st;
  end

  err_sticky_word #(.KEEP(KEEP_MASK)) u_word (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .word_o(err_status_o)
  );

  assign fatal_irq_o   = |err_status_o;
  assign fatal_alert_o = |err_status_o[CHK_LSB +: NUM_CHK];
endmodule

// File: rtl/err_sticky_agg_chk.sv
module err_sticky_agg_chk
  import errsum_pkg::*;
#(
  parameter int unsigned NUM_FIFO = 16,
  parameter int unsigned NUM_CHK  = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_FIFO-1:0] fifo_err_i,
  input logic [NUM_FIFO-1:0] fifo_full_i,
  input logic [NUM_FIFO-1:0] fifo_empty_i,
  input logic [NUM_FIFO-1:0] fifo_wr_i,
  input logic [NUM_FIFO-1:0] fifo_rd_i,
  input logic [NUM_CHK-1:0]  chk_err_i,
  input logic                cfg_wen_i,
  input logic                test_wr_i,
  input logic [WORD_W-1:0]   force_vec,
  input logic [WORD_W-1:0]   err_status_o,
  input logic                fatal_irq_o,
  input logic                fatal_alert_o
);
  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_src
    // R2
    fifo_src_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_err_i[g] |=> err_status_o[FIFO_LSB + g]);
  end

  for (genvar k = 0; k < NUM_CHK; k++) begin : g_chk
    // R7
    checker_src_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_err_i[k] |=> err_status_o[CHK_LSB + k]);
  end

  // R3
  overflow_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fifo_err_i & fifo_wr_i & fifo_full_i)) |=> err_status_o[TYPE_WR]);

  // R4
  underflow_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fifo_err_i & fifo_rd_i & fifo_empty_i)) |=> err_status_o[TYPE_RD]);

  // R5
  state_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fifo_err_i & fifo_full_i & fifo_empty_i)) |=> err_status_o[TYPE_ST]);

  // R8
  bits_stay_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_status_o & $past(err_status_o)) == $past(err_status_o));

  // R9
  force_single_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(force_vec));

  // R9
  force_one_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_wen_i && test_wr_i) |=> force_vec == '0);

  // R10
  locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_wr_i && !cfg_wen_i) |=> force_vec == '0);

  // R11
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_status_o[19:16] == 4'd0) && !err_status_o[27] && !err_status_o[31]);

  // R12
  irq_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_irq_o |=> fatal_irq_o);

  // R12
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fatal_irq_o) |-> $past((|fifo_err_i) || (|chk_err_i) || (|force_vec)));

  // R13
  alert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fatal_alert_o) |-> $past((|chk_err_i) || (|force_vec[CHK_LSB +: NUM_CHK])));
endmodule

bind err_sticky_agg err_sticky_agg_chk #(.NUM_FIFO(NUM_FIFO), .NUM_CHK(NUM_CHK)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_err_i   (fifo_err_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_empty_i (fifo_empty_i),
  .fifo_wr_i    (fifo_wr_i),
  .fifo_rd_i    (fifo_rd_i),
  .chk_err_i    (chk_err_i),
  .cfg_wen_i    (cfg_wen_i),
  .test_wr_i    (test_wr_i),
  .force_vec    (force_vec),
  .err_status_o (err_status_o),
  .fatal_irq_o  (fatal_irq_o),
  .fatal_alert_o(fatal_alert_o)
);

// File: tb/err_sticky_agg_test.sv
module err_sticky_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] fe = '0, ff = '0, fm = '0, fw = '0, fr = '0;
  logic [6:0]  ce = '0;
  logic        wen = 1'b1, twr = 1'b0;
  logic [4:0]  tidx = '0;
  logic [31:0] status;
  logic        irq, alert;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [31:0] exp_word = '0;
  logic [31:0] pend = '0;

  always #4 clk = ~clk;

  err_sticky_agg uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_err_i(fe), .fifo_full_i(ff), .fifo_empty_i(fm),
    .fifo_wr_i(fw), .fifo_rd_i(fr), .chk_err_i(ce),
    .cfg_wen_i(wen), .test_wr_i(twr), .test_idx_i(tidx),
    .err_status_o(status), .fatal_irq_o(irq), .fatal_alert_o(alert)
  );

  // Bits that exist: FIFO 0..15, checkers 20..26, types 28..30.
  function automatic bit idx_exists(input int i);
    return (i <= 15) || (i >= 20 && i <= 26) || (i >= 28 && i <= 30);
  endfunction

  function automatic logic [31:0] cycle_bits(input logic [15:0] e, input logic [15:0] f,
                                             input logic [15:0] m, input logic [15:0] w,
                                             input logic [15:0] r, input logic [6:0] c);
    logic [31:0] v = '0;
    for (int i = 0; i < 16; i++) begin
      if (e[i]) begin
        v[i] = 1'b1;
        if (w[i] && f[i]) v[28] = 1'b1;
        if (r[i] && m[i]) v[29] = 1'b1;
        if (f[i] && m[i]) v[30] = 1'b1;
      end
    end
    for (int j = 0; j < 7; j++) if (c[j]) v[20 + j] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, status, exp_word);
    check("R12", {31'd0, irq}, {31'd0, |exp_word});
    check("R13", {31'd0, alert}, {31'd0, |exp_word[26:20]});
  endtask

  task automatic step(input string tag, input logic [15:0] e, input logic [15:0] f,
                      input logic [15:0] m, input logic [15:0] w, input logic [15:0] r,
                      input logic [6:0] c, input logic t, input logic [4:0] ti,
                      input logic we);
    @(negedge clk);
    fe = e; ff = f; fm = m; fw = w; fr = r; ce = c; twr = t; tidx = ti; wen = we;
    exp_word = exp_word | cycle_bits(e, f, m, w, r, c) | pend;
    pend = (t && we && idx_exists(int'(ti))) ? (32'd1 << ti) : 32'd0;
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, '0, '0, '0, '0, '0, '0, 1'b0, 5'd0, 1'b1);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    fe = '0; ff = '0; fm = '0; fw = '0; fr = '0; ce = '0; twr = 1'b0; wen = 1'b1;
    exp_word = '0;
    pend = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    #1;
    compare_all("R1");

    // R2 / R6: pulse without a matching cause sets only the source bit
    step("R2", 16'h0001, '0, '0, 16'h0001, 16'h0001, '0, 1'b0, 5'd0, 1'b1);
    idle("R6");
    // R3 overflow type
    step("R3", 16'h8000, 16'h8000, '0, 16'h8000, '0, '0, 1'b0, 5'd0, 1'b1);
    // R4 underflow type
    step("R4", 16'h0040, '0, 16'h0040, '0, 16'h0040, '0, 1'b0, 5'd0, 1'b1);
    // R5 state type
    step("R5", 16'h0100, 16'h0100, 16'h0100, '0, '0, '0, 1'b0, 5'd0, 1'b1);
    // R7 checker 0 and checker 6
    step("R7", '0, '0, '0, '0, '0, 7'h41, 1'b0, 5'd0, 1'b1);
    // R8 nothing new for several cycles; bits stay
    for (int k = 0; k < 5; k++) idle("R8");

    do_reset();
    // R10 locked test write to a live bit is ignored
    step("R10", '0, '0, '0, '0, '0, '0, 1'b1, 5'd22, 1'b0);
    idle("R10");
    idle("R10");
    // R9 unlocked write forces bit 22 two edges later
    step("R9", '0, '0, '0, '0, '0, '0, 1'b1, 5'd22, 1'b1);
    idle("R9");
    // R11 forcing reserved indices leaves them zero
    step("R11", '0, '0, '0, '0, '0, '0, 1'b1, 5'd17, 1'b1);
    step("R11", '0, '0, '0, '0, '0, '0, 1'b1, 5'd27, 1'b1);
    step("R11", '0, '0, '0, '0, '0, '0, 1'b1, 5'd31, 1'b1);
    idle("R11");
    // R9 forcing a type bit and a FIFO bit
    step("R9", '0, '0, '0, '0, '0, '0, 1'b1, 5'd29, 1'b1);
    step("R9", '0, '0, '0, '0, '0, '0, 1'b1, 5'd3, 1'b1);
    idle("R9");

    do_reset();
    // R12 interrupt from a FIFO fault alone, no alert (R13)
    step("R12", 16'h0200, '0, '0, '0, '0, '0, 1'b0, 5'd0, 1'b1);
    idle("R13");

    // Random trials
    for (int t = 0; t < 40; t++) begin
      do_reset();
      for (int s = 0; s < 20; s++) begin
        logic [15:0] e, f, m, w, r;
        logic [6:0] c;
        e = 16'($urandom & $urandom & $urandom);
        f = 16'($urandom);
        m = 16'($urandom);
        w = 16'($urandom);
        r = 16'($urandom);
        c = 7'($urandom & $urandom & $urandom & $urandom);
        step("R8", e, f, m, w, r, c, ($urandom % 4) == 0, 5'($urandom), ($urandom % 2) == 0);
      end
      idle("R9");
    end

    finish_run();
  end
endmodule